// File: doc/BRIEF.md
# Directory Home Coherence Engine

This block is the home-side controller of a small directory-based coherence scheme. It owns the backing value of each of a fixed set of addresses. It also keeps, for each address, a bit vector of the cache sites that hold a copy, and a flag that marks the address as either settled or waiting for purges to finish. Messages arrive one per cycle on a single input channel and are never refused. The engine answers on a single output channel, one cycle after the message that caused the answer.

Cache requests are answered with data when the address is settled. A site that is already recorded as a holder gets no answer. When the address is waiting on purges, the request is parked in a small side store, so later messages on the channel still go through. Writebacks update the stored value and are acknowledged. Purge notices only clear the sender. A recall message starts a purge: every recorded holder receives one purge message, sent as a multicast. When the holder set of a purging address becomes empty, the address settles again. Parked requests are then replayed in arrival order, in cycles when no new message arrives.

Top module: `dir_home_engine`

## Requirements
- R1: After reset every address is settled with an empty holder set, every stored value is zero and `out_valid` is low.
- R2: A cache request (`in_kind` 2'b00) to a settled address from a site not in its holder set produces, on the next cycle, a data reply (`out_kind` 2'b00) whose `out_dest` is the one-hot bit of the site, with the address and the stored value. The site joins the holder set.
- R3: A cache request from a site already in the holder set of a settled address produces no output and changes nothing.
- R4: A recall (`in_kind` 2'b11) to a settled address with a non-empty holder set produces one purge message (`out_kind` 2'b10) whose `out_dest` equals the holder set, and marks the address as purging. A recall to an empty set or to an address already purging produces no output.
- R5: A writeback (`in_kind` 2'b01) stores `in_data` as the new value, removes the sender from the holder set and produces on the next cycle an acknowledgement (`out_kind` 2'b01, `out_data` zero) addressed one-hot to the sender.
- R6: A purge notice (`in_kind` 2'b10) removes the sender from the holder set and produces no output.
- R7: When a writeback or purge notice empties the holder set of a purging address, the address becomes settled.
- R8: A cache request to a purging address produces no output and is parked. Messages that follow it are processed normally.
- R9: In a cycle with `in_valid` low, the oldest parked request whose address is settled is replayed with the R2/R3 rules, and its answer appears on the next cycle. Among eligible requests, the one that arrived first is replayed first.
- R10: A parked request is never replayed in a cycle with `in_valid` high.
- R11: A parked request for an address that is still purging does not hold back a younger parked request whose address has settled.
- R12: `out_valid` is high for exactly one cycle per answer, and `out_kind` is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present |
| in_kind | input | 2 | 00 cache request, 01 writeback, 10 purge notice, 11 recall |
| in_site | input | SITE_W | Index of the sending site |
| in_addr | input | ADDR_W | Address the message refers to |
| in_data | input | DATA_W | Value carried by a writeback |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 2 | 00 data reply, 01 writeback ack, 10 purge |
| out_dest | output | N_SITES | Destination site mask |
| out_addr | output | ADDR_W | Address of the outgoing message |
| out_data | output | DATA_W | Reply value, zero otherwise |

## Verification
Two functions can compete for the same cycle: a new incoming message and the replay of a parked request whose address has just settled. The bench settles an address that has parked requests, then keeps sending messages that produce no output. Any reply that shows up during that stretch breaks the ordered expectation queue. The replies must then appear, in arrival order, only once the input goes idle.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        IN_CREQ   = 2'b00,
        IN_WBACK  = 2'b01,
        IN_PURGED = 2'b10,
        IN_RECALL = 2'b11
    } in_kind_e;

    typedef enum logic [1:0] {
        OUT_REPLY = 2'b00,
        OUT_ACK   = 2'b01,
        OUT_PURGE = 2'b10
    } out_kind_e;

endpackage

// File: rtl/dir_state_table.sv
module dir_state_table #(
    parameter int N_ADDR  = 16,
    parameter int N_SITES = 4,
    parameter int DATA_W  = 32,
    localparam int ADDR_W = $clog2(N_ADDR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_transient,
    output logic [N_SITES-1:0]  rd_sharers,
    output logic [DATA_W-1:0]   rd_data,
    output logic [N_ADDR-1:0]   transient_vec,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_transient,
    input  logic [N_SITES-1:0]  wr_sharers,
    input  logic                wr_data_en,
    input  logic [DATA_W-1:0]   wr_data
);

    typedef struct packed {
        logic [N_ADDR-1:0]               trans;
        logic [N_ADDR-1:0][N_SITES-1:0]  shr;
        logic [N_ADDR-1:0][DATA_W-1:0]   mem;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    assign rd_transient  = tbl_q.trans[rd_addr];
    assign rd_sharers    = tbl_q.shr[rd_addr];
    assign rd_data       = tbl_q.mem[rd_addr];
    assign transient_vec = tbl_q.trans;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.trans[wr_addr] = wr_transient;
            tbl_d.shr[wr_addr]   = wr_sharers;
            if (wr_data_en) begin
                tbl_d.mem[wr_addr] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/dir_hold_buf.sv
module dir_hold_buf #(
    parameter int DEPTH  = 4,
    parameter int SITE_W = 2,
    parameter int N_ADDR = 16,
    localparam int ADDR_W = $clog2(N_ADDR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [SITE_W-1:0]  push_site,
    input  logic [ADDR_W-1:0]  push_addr,
    input  logic               pop,
    input  logic [N_ADDR-1:0]  transient_vec,
    output logic               sel_valid,
    output logic [SITE_W-1:0]  sel_site,
    output logic [ADDR_W-1:0]  sel_addr
);

    typedef struct packed {
        logic [DEPTH-1:0]              vld;
        logic [DEPTH-1:0][SITE_W-1:0]  site;
        logic [DEPTH-1:0][ADDR_W-1:0]  addr;
    } hold_t;

    hold_t hb_d, hb_q;
    logic [DEPTH-1:0] eligible;

    // entries stay packed from slot 0; slot 0 is the oldest
    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign eligible[g] = hb_q.vld[g] && !transient_vec[hb_q.addr[g]];
    end

    always_comb begin
        int sel_idx;
        int tail;
        sel_idx   = DEPTH;
        sel_valid = 1'b0;
        sel_site  = '0;
        sel_addr  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                sel_idx = i;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (i == sel_idx) begin
                sel_valid = 1'b1;
                sel_site  = hb_q.site[i];
                sel_addr  = hb_q.addr[i];
            end
        end

        hb_d = hb_q;
        if (pop && sel_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= sel_idx) begin
                    if (i < DEPTH - 1) begin
                        hb_d.vld[i]  = hb_q.vld[i+1];
                        hb_d.site[i] = hb_q.site[i+1];
                        hb_d.addr[i] = hb_q.addr[i+1];
                    end else begin
                        hb_d.vld[i]  = 1'b0;
                    end
                end
            end
        end

        tail = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hb_d.vld[i]) begin
                tail = tail + 1;
            end
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == tail) begin
                    hb_d.vld[i]  = 1'b1;
                    hb_d.site[i] = push_site;
                    hb_d.addr[i] = push_addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_q <= '0;
        end else begin
            hb_q <= hb_d;
        end
    end

endmodule

// File: rtl/dir_home_engine.sv
module dir_home_engine
    import dir_pkg::*;
#(
    parameter int N_SITES = 4,
    parameter int N_ADDR  = 16,
    parameter int DATA_W  = 32,
    localparam int SITE_W = $clog2(N_SITES),
    localparam int ADDR_W = $clog2(N_ADDR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_kind,
    input  logic [SITE_W-1:0]   in_site,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic [1:0]          out_kind,
    output logic [N_SITES-1:0]  out_dest,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [DATA_W-1:0]   out_data
);

    localparam int HOLD_DEPTH = N_SITES;

    typedef struct packed {
        logic               valid;
        out_kind_e          kind;
        logic [N_SITES-1:0] dest;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } out_t;

    out_t out_d, out_q;

    logic [ADDR_W-1:0]  rd_addr;
    logic               rd_transient;
    logic [N_SITES-1:0] rd_sharers;
    logic [DATA_W-1:0]  rd_data;
    logic [N_ADDR-1:0]  transient_vec;
    logic               wr_en, wr_transient, wr_data_en;
    logic [N_SITES-1:0] wr_sharers;
    logic [DATA_W-1:0]  wr_data;
    logic               push, pop;
    logic               sel_valid;
    logic [SITE_W-1:0]  sel_site;
    logic [ADDR_W-1:0]  sel_addr;
    logic [N_SITES-1:0] in_bit, sel_bit;

    dir_state_table #(
        .N_ADDR  (N_ADDR),
        .N_SITES (N_SITES),
        .DATA_W  (DATA_W)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_addr       (rd_addr),
        .rd_transient  (rd_transient),
        .rd_sharers    (rd_sharers),
        .rd_data       (rd_data),
        .transient_vec (transient_vec),
        .wr_en         (wr_en),
        .wr_addr       (rd_addr),
        .wr_transient  (wr_transient),
        .wr_sharers    (wr_sharers),
        .wr_data_en    (wr_data_en),
        .wr_data       (wr_data)
    );

    dir_hold_buf #(
        .DEPTH  (HOLD_DEPTH),
        .SITE_W (SITE_W),
        .N_ADDR (N_ADDR)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (push),
        .push_site     (in_site),
        .push_addr     (in_addr),
        .pop           (pop),
        .transient_vec (transient_vec),
        .sel_valid     (sel_valid),
        .sel_site      (sel_site),
        .sel_addr      (sel_addr)
    );

    for (genvar s = 0; s < N_SITES; s++) begin : g_bits
        assign in_bit[s]  = (in_site  == SITE_W'(s));
        assign sel_bit[s] = (sel_site == SITE_W'(s));
    end

    // one table access per cycle: a new message wins over a replay
    assign rd_addr = in_valid ? in_addr : sel_addr;

    always_comb begin
        logic [N_SITES-1:0] cleared;
        out_d        = '0;
        out_d.kind   = OUT_REPLY;
        out_d.addr   = rd_addr;
        wr_en        = 1'b0;
        wr_transient = rd_transient;
        wr_sharers   = rd_sharers;
        wr_data_en   = 1'b0;
        wr_data      = in_data;
        push         = 1'b0;
        pop          = 1'b0;
        cleared      = rd_sharers & ~in_bit;

        if (in_valid) begin
            unique case (in_kind_e'(in_kind))
                IN_CREQ: begin
                    if (rd_transient) begin
                        push = 1'b1;
                    end else if ((rd_sharers & in_bit) == '0) begin
                        wr_en      = 1'b1;
                        wr_sharers = rd_sharers | in_bit;
                        out_d.valid = 1'b1;
                        out_d.kind  = OUT_REPLY;
                        out_d.dest  = in_bit;
                        out_d.data  = rd_data;
                    end
                end
                IN_WBACK: begin
                    wr_en      = 1'b1;
                    wr_data_en = 1'b1;
                    wr_sharers = cleared;
                    if (rd_transient && cleared == '0) begin
                        wr_transient = 1'b0;
                    end
                    out_d.valid = 1'b1;
                    out_d.kind  = OUT_ACK;
                    out_d.dest  = in_bit;
                end
                IN_PURGED: begin
                    wr_en      = 1'b1;
                    wr_sharers = cleared;
                    if (rd_transient && cleared == '0) begin
                        wr_transient = 1'b0;
                    end
                end
                IN_RECALL: begin
                    if (!rd_transient && rd_sharers != '0) begin
                        wr_en        = 1'b1;
                        wr_transient = 1'b1;
                        out_d.valid  = 1'b1;
                        out_d.kind   = OUT_PURGE;
                        out_d.dest   = rd_sharers;
                    end
                end
                default: ;
            endcase
        end else if (sel_valid) begin
            pop = 1'b1;
            if ((rd_sharers & sel_bit) == '0) begin
                wr_en       = 1'b1;
                wr_sharers  = rd_sharers | sel_bit;
                out_d.valid = 1'b1;
                out_d.kind  = OUT_REPLY;
                out_d.dest  = sel_bit;
                out_d.data  = rd_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_kind  = out_q.kind;
    assign out_dest  = out_q.dest;
    assign out_addr  = out_q.addr;
    assign out_data  = out_q.data;

endmodule

// File: rtl/dir_home_engine_chk.sv
module dir_home_engine_chk #(
    parameter int N_SITES = 4,
    parameter int SITE_W  = 2,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_kind,
    input logic [SITE_W-1:0]  in_site,
    input logic               out_valid,
    input logic [1:0]         out_kind,
    input logic [N_SITES-1:0] out_dest,
    input logic [DATA_W-1:0]  out_data
);

    p_reply_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b00) |-> $countones(out_dest) == 1);

    p_creq_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b00) |=>
            (!out_valid || (out_kind == 2'b00 && out_dest == (N_SITES'(1) << $past(in_site)))));

    p_purge_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b10) |-> out_dest != '0);

    p_recall_only_purge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11) |=> (!out_valid || out_kind == 2'b10));

    p_wb_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01) |=>
            (out_valid && out_kind == 2'b01 && out_data == '0 &&
             out_dest == (N_SITES'(1) << $past(in_site))));

    p_purged_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b10) |=> !out_valid);

    p_kind_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_kind != 2'b11);

endmodule

bind dir_home_engine dir_home_engine_chk #(
    .N_SITES (N_SITES),
    .SITE_W  (SITE_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .in_site   (in_site),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_dest  (out_dest),
    .out_data  (out_data)
);

// File: tb/dir_home_engine_tb.sv
module dir_home_engine_tb;

    localparam int N_SITES = 4;
    localparam int N_ADDR  = 16;
    localparam int DATA_W  = 32;
    localparam int SITE_W  = 2;
    localparam int ADDR_W  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [1:0]         in_kind = '0;
    logic [SITE_W-1:0]  in_site = '0;
    logic [ADDR_W-1:0]  in_addr = '0;
    logic [DATA_W-1:0]  in_data = '0;
    logic               out_valid;
    logic [1:0]         out_kind;
    logic [N_SITES-1:0] out_dest;
    logic [ADDR_W-1:0]  out_addr;
    logic [DATA_W-1:0]  out_data;

    always #2 clk = ~clk;

    dir_home_engine #(.N_SITES(N_SITES), .N_ADDR(N_ADDR), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_site(in_site), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
        .out_addr(out_addr), .out_data(out_data)
    );

    typedef struct packed {
        logic [1:0]         kind;
        logic [N_SITES-1:0] dest;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [7:0]         req;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [N_SITES-1:0] onehot(input int s);
        return N_SITES'(1) << s;
    endfunction

    task automatic expect_out(input logic [1:0] k, input logic [N_SITES-1:0] d,
                              input int a, input logic [DATA_W-1:0] v, input int rq);
        exp_t e;
        e.kind = k; e.dest = d; e.addr = ADDR_W'(a); e.data = v; e.req = 8'(rq);
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [1:0] k, input int s, input int a, input logic [DATA_W-1:0] v);
        @(posedge clk); #1;
        in_valid = 1'b1; in_kind = k; in_site = SITE_W'(s); in_addr = ADDR_W'(a); in_data = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    // monitor: every output must match the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected output: kind=%0d dest=%b addr=%0d data=%h expected none",
                             out_kind, out_dest, out_addr, out_data);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (out_kind != e.kind || out_dest != e.dest || out_addr != e.addr || out_data != e.data) begin
                        n_bad++;
                        $display("FAIL R%0d: got kind=%0d dest=%b addr=%0d data=%h expected kind=%0d dest=%b addr=%0d data=%h",
                                 e.req, out_kind, out_dest, out_addr, out_data, e.kind, e.dest, e.addr, e.data);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, output idle
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid=%b expected 0", out_valid);
        end

        // R1/R2: first request reads zero, reply one-hot
        send(2'b00, 0, 3, 0);  expect_out(2'b00, onehot(0), 3, 32'h0, 1);
        // R3: repeated request from a holder is silent
        send(2'b00, 0, 3, 0);
        // R5: writeback stores value and is acknowledged
        send(2'b01, 0, 3, 32'hA5); expect_out(2'b01, onehot(0), 3, 32'h0, 5);
        // R2/R5: new readers see the written value
        send(2'b00, 1, 3, 0);  expect_out(2'b00, onehot(1), 3, 32'hA5, 2);
        send(2'b00, 2, 3, 0);  expect_out(2'b00, onehot(2), 3, 32'hA5, 2);
        // R4: recall multicasts to holders {1,2}
        send(2'b11, 0, 3, 0);  expect_out(2'b10, 4'b0110, 3, 32'h0, 4);
        // R4: second recall while purging is silent
        send(2'b11, 0, 3, 0);
        // R8: requests to purging address parked, later traffic still flows
        send(2'b00, 3, 3, 0);
        send(2'b00, 0, 3, 0);
        send(2'b01, 2, 7, 32'h77); expect_out(2'b01, onehot(2), 7, 32'h0, 8);
        // R4: recall of empty set is silent
        send(2'b11, 1, 5, 0);
        // R6: purge notice silent, address still purging (site 2 left)
        send(2'b10, 1, 3, 0);
        // R7: last holder writes back, address settles
        send(2'b01, 2, 3, 32'h3C); expect_out(2'b01, onehot(2), 3, 32'h0, 7);
        // R10: silent traffic keeps replays waiting
        send(2'b10, 0, 9, 0);
        send(2'b10, 1, 9, 0);
        send(2'b00, 0, 3, 0);  // R8 path: parked entry not yet replayed, so site 0 not holder
        expect_out(2'b00, onehot(0), 3, 32'h3C, 10);
        // R9: replay in arrival order: site 3 first; site 0 now holder -> silent
        idle(1);
        expect_out(2'b00, onehot(3), 3, 32'h3C, 9);
        idle(4);

        // R11: younger eligible parked request overtakes older blocked one
        send(2'b00, 1, 4, 0);  expect_out(2'b00, onehot(1), 4, 32'h0, 2);
        send(2'b00, 1, 6, 0);  expect_out(2'b00, onehot(1), 6, 32'h0, 2);
        send(2'b11, 0, 4, 0);  expect_out(2'b10, onehot(1), 4, 32'h0, 4);
        send(2'b11, 0, 6, 0);  expect_out(2'b10, onehot(1), 6, 32'h0, 4);
        send(2'b00, 2, 4, 0);
        send(2'b00, 3, 6, 0);
        send(2'b10, 1, 6, 0);
        idle(1);
        expect_out(2'b00, onehot(3), 6, 32'h0, 11);
        idle(3);
        send(2'b10, 1, 4, 0);
        idle(1);
        expect_out(2'b00, onehot(2), 4, 32'h0, 11);
        idle(3);

        // R6: purge notice in settled state clears holder bit
        send(2'b00, 1, 10, 0); expect_out(2'b00, onehot(1), 10, 32'h0, 6);
        send(2'b10, 1, 10, 0);
        send(2'b00, 1, 10, 0); expect_out(2'b00, onehot(1), 10, 32'h0, 6);
        // R5/R12: back-to-back writebacks each acknowledged once
        send(2'b01, 3, 12, 32'hDEAD_BEEF); expect_out(2'b01, onehot(3), 12, 32'h0, 12);
        send(2'b01, 2, 12, 32'h1234_5678); expect_out(2'b01, onehot(2), 12, 32'h0, 12);
        send(2'b00, 0, 12, 0); expect_out(2'b00, onehot(0), 12, 32'h1234_5678, 5);
        idle(6);

        // R12: nothing left owed
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R12: %0d outputs missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule